// File: doc/BRIEF.md
# Odd-Sum Integer Square Root

This block returns the floor of the square root of an unsigned operand without dividing or multiplying. It relies on one identity: the squares 1, 4, 9, 16 and so on are reached by adding the odd numbers 3, 5, 7 and so on to a running total. The block keeps a running sum and an odd step, and it keeps adding the step to the sum until the sum passes the operand. The root is then read from the last odd step: halve it and subtract one.

Every iteration is unrolled into a fixed chain of combinational stages, and there is no sequencing state. On each falling clock edge the root of the operand present at that edge is captured into the output register. An active-low asynchronous reset clears that register. A caller holds the operand steady and reads the result after the next falling edge.

Top module: `odd_sum_isqrt`

## Requirements
- R1: For every operand value from 0 to 1023, the registered result equals the largest integer r such that r*r does not exceed the operand.
- R2: The result register loads only on a falling clock edge. A change of operand has no effect on the result before the next falling edge, and a rising edge leaves the result unchanged.
- R3: Operands 4 through 8 yield 2, and operands 9 through 15 yield 3.
- R4: An operand of 0 yields a result of 0. Without a correction, the loop body, which always runs at least once, would give 1 here.
- R5: Operands 1, 2 and 3 yield 1.
- R6: Operand 1023 yields 31. The iteration always ends within the fixed bound of 32 stages, and the 11-bit running sum that reaches 1024 does not overflow.
- R7: While the active-low reset is asserted, the result is 0, whatever the clock and the operand do.
- R8: For each perfect square k*k with k from 1 to 31, the result is k, and for k*k-1 the result is k-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The result loads on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the result |
| operand | input | 10 | Unsigned value whose root is taken |
| root | output | 5 | Registered floor of the square root |

## Verification
The bench first drives the smallest operands: zero, which is the special case, and one to three, which finish after a single step of the loop. These separate a missing zero correction from a faulty termination test. Pairs of perfect squares and the value just below each square then test whether the termination test is strict. A wrong comparison moves the result by one at exactly those values. Operand 1023 exercises the deepest stage and the widest sum. A full sweep of all 1024 operands is then compared against a reference that counts squares upward. Separate timed checks around the rising and falling edges, and a reset applied in the middle of a run, show which edge loads the register.

// File: rtl/isqrt_pkg.sv
`timescale 1ns/1ps
package isqrt_pkg;
  // Seed values of the odd-sum iteration: sum starts at 1*1, step at 3.
  localparam int unsigned SUM_SEED = 1;
  localparam int unsigned ODD_SEED = 3;
  localparam int unsigned ODD_GAP  = 2;

  // Number of result bits needed for an operand of in_w bits.
  function automatic int unsigned root_bits(int unsigned in_w);
    return (in_w + 1) / 2;
  endfunction
endpackage

// File: rtl/isqrt_step.sv
`timescale 1ns/1ps
// One unrolled iteration: while still running, fold the odd step into the
// sum, advance the step by two and test whether the sum passed the operand.
module isqrt_step
  import isqrt_pkg::*;
#(
  parameter int unsigned ACC_W = 11
) (
  input  logic [ACC_W-1:0] opnd,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [ACC_W-1:0] odd_i,
  input  logic             run_i,
  output logic [ACC_W-1:0] sum_o,
  output logic [ACC_W-1:0] odd_o,
  output logic             run_o
);
  function automatic logic [ACC_W-1:0] add_odd(logic [ACC_W-1:0] s,
                                               logic [ACC_W-1:0] o);
    return s + o;
  endfunction

  function automatic logic [ACC_W-1:0] next_odd(logic [ACC_W-1:0] o);
    return o + ACC_W'(ODD_GAP);
  endfunction

  logic [ACC_W-1:0] sum_adv;
  logic             passed;

  always_comb begin
    sum_adv = add_odd(sum_i, odd_i);
    passed  = sum_adv > opnd;
    if (run_i) begin
      sum_o = sum_adv;
      odd_o = next_odd(odd_i);
      run_o = !passed;
    end else begin
      sum_o = sum_i;
      odd_o = odd_i;
      run_o = 1'b0;
    end
  end
endmodule

// File: rtl/isqrt_chain.sv
`timescale 1ns/1ps
// Fixed-length chain of iteration stages. Stage 0 always runs (do-while).
module isqrt_chain
  import isqrt_pkg::*;
#(
  parameter int unsigned ACC_W = 11,
  parameter int unsigned STEPS = 32
) (
  input  logic [ACC_W-1:0] opnd,
  output logic [ACC_W-1:0] last_odd,
  output logic             done
);
  logic [ACC_W-1:0] sum_w [STEPS+1];
  logic [ACC_W-1:0] odd_w [STEPS+1];
  logic             run_w [STEPS+1];

  assign sum_w[0] = ACC_W'(SUM_SEED);
  assign odd_w[0] = ACC_W'(ODD_SEED);
  assign run_w[0] = 1'b1;

  for (genvar i = 0; i < STEPS; i++) begin : g_stage
    isqrt_step #(.ACC_W(ACC_W)) u_step (
      .opnd  (opnd),
      .sum_i (sum_w[i]),
      .odd_i (odd_w[i]),
      .run_i (run_w[i]),
      .sum_o (sum_w[i+1]),
      .odd_o (odd_w[i+1]),
      .run_o (run_w[i+1])
    );
  end

  logic [ACC_W-1:0] unused_sum;
  assign unused_sum = sum_w[STEPS];
  assign last_odd   = odd_w[STEPS];
  assign done       = !run_w[STEPS];
endmodule

// File: rtl/isqrt_finish.sv
`timescale 1ns/1ps
// Turns the final odd step into the root: halve it, subtract one, and force
// zero for a zero operand (the loop body always ran once).
module isqrt_finish #(
  parameter int unsigned ACC_W = 11,
  parameter int unsigned OUT_W = 5
) (
  input  logic [ACC_W-1:0] last_odd,
  input  logic             zero_in,
  output logic [OUT_W-1:0] root_val
);
  function automatic logic [OUT_W-1:0] odd_to_root(logic [ACC_W-1:0] o);
    logic [ACC_W-1:0] half;
    half = o >> 1;
    return OUT_W'(half - ACC_W'(1));
  endfunction

  assign root_val = zero_in ? '0 : odd_to_root(last_odd);
endmodule

// File: rtl/odd_sum_isqrt.sv
`timescale 1ns/1ps
module odd_sum_isqrt
  import isqrt_pkg::*;
#(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned OUT_W = root_bits(IN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  operand,
  output logic [OUT_W-1:0] root
);
  localparam int unsigned ACC_W = IN_W + 1;
  localparam int unsigned STEPS = 1 << OUT_W;

  // Named internal events, visible to the bound checker.
  logic [ACC_W-1:0] opnd_ext;
  logic [ACC_W-1:0] last_odd;
  logic             chain_done;
  logic             zero_case;
  logic [OUT_W-1:0] root_next;

  assign opnd_ext  = ACC_W'(operand);
  assign zero_case = (operand == '0);

  isqrt_chain #(.ACC_W(ACC_W), .STEPS(STEPS)) u_chain (
    .opnd     (opnd_ext),
    .last_odd (last_odd),
    .done     (chain_done)
  );

  isqrt_finish #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_finish (
    .last_odd (last_odd),
    .zero_in  (zero_case),
    .root_val (root_next)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) root <= '0;
    else        root <= root_next;
  end
endmodule

// File: rtl/odd_sum_isqrt_chk.sv
`timescale 1ns/1ps
module odd_sum_isqrt_chk #(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned OUT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IN_W-1:0]  operand,
  input logic [OUT_W-1:0] root,
  input logic             chain_done
);
  logic [2*OUT_W+1:0] sq_lo;
  logic [2*OUT_W+1:0] sq_hi;

  always_comb begin
    sq_lo = (2*OUT_W+2)'(root) * (2*OUT_W+2)'(root);
    sq_hi = ((2*OUT_W+2)'(root) + 1) * ((2*OUT_W+2)'(root) + 1);
  end

  // R1: the captured root squared never exceeds the operand it came from.
  p_root_sq_le_r1: assert property (@(negedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sq_lo <= (2*OUT_W+2)'($past(operand)));

  // R1: the next root up, squared, lies above that operand.
  p_root_next_gt_r1: assert property (@(negedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sq_hi > (2*OUT_W+2)'($past(operand)));

  // R4: a zero operand gives a zero root.
  p_zero_root_r4: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(operand) == '0) |-> root == '0);

  // R6: the chain of stages always terminates within its bound.
  p_chain_ends_r6: assert property (@(negedge clk) disable iff (!rst_n)
    chain_done);
endmodule

bind odd_sum_isqrt odd_sum_isqrt_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .operand    (operand),
  .root       (root),
  .chain_done (chain_done)
);

// File: tb/odd_sum_isqrt_test.sv
`timescale 1ns/1ps
module odd_sum_isqrt_test;
  localparam int unsigned IN_W  = 10;
  localparam int unsigned OUT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IN_W-1:0]  operand = '0;
  logic [OUT_W-1:0] root;

  always #5 clk = ~clk;

  odd_sum_isqrt #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .root(root));

  typedef struct {
    int unsigned arg;
    int unsigned want;
    string       req;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  event  sample_ev;

  // Counts squares upward: largest r with r*r <= x.
  function automatic int unsigned ref_root(int unsigned x);
    int unsigned r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  task automatic check(string req, int unsigned got, int unsigned want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, want);
    end
  endtask

  // Driver: apply operand after a rising edge, queue the expectation,
  // signal the monitor two cycles later (away from the falling edge).
  task automatic drive(int unsigned v, int unsigned want, string req);
    @(posedge clk);
    #1 operand = IN_W'(v);
    sb.push_back('{v, want, req});
    @(posedge clk);
    @(posedge clk);
    #2 -> sample_ev;
  endtask

  // Monitor: pop one expectation per sample event and compare.
  initial begin
    forever begin
      @(sample_ev);
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        check($sformatf("%s operand=%0d", it.req, it.arg), root, it.want);
      end
    end
  end

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      wrap_up();
    end
  end

  initial begin
    // R7: reset state
    #7 check("R7 reset state", root, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    drive(0, 0, "R4");
    for (int v = 1; v <= 3; v++) drive(v, 1, "R5");
    for (int v = 4; v <= 8; v++) drive(v, 2, "R3");
    for (int v = 9; v <= 15; v++) drive(v, 3, "R3");
    drive(1023, 31, "R6");
    for (int k = 1; k <= 31; k++) begin
      drive(k * k, k, "R8 square");
      drive(k * k - 1, k - 1, "R8 below square");
    end

    // R2: operand 100 after a rising edge; old value until falling edge.
    drive(24, 4, "R2 setup");
    @(posedge clk); #1 operand = 10'd100;
    #2 check("R2 before falling edge", root, 4);
    @(negedge clk); #1 check("R2 after falling edge", root, 10);
    @(posedge clk); #1 operand = 10'd50;
    #1 check("R2 rising edge holds", root, 10);
    @(negedge clk); #1 check("R2 next falling edge", root, 7);

    // R7: asynchronous reset in the middle of a run.
    drive(900, 30, "R7 before reset");
    @(posedge clk); #2 rst_n = 1'b0;
    #1 check("R7 async clear", root, 0);
    @(negedge clk); #1 check("R7 held through falling edge", root, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #1 check("R7 resume", root, 30);

    // R1: full sweep against the reference.
    for (int v = 0; v < (1 << IN_W); v++) drive(v, ref_root(v), "R1");

    @(posedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1: actual=%0d expected=0 pending items", sb.size());
    end
    wrap_up();
  end
endmodule